// File: doc/BRIEF.md
# Time-Sliced Multi-Plane Cell Crossbar

This block switches fixed-size cells between `NPORTS` ports through `NPLANES` identical crossbar planes. A cell is never split: each plane carries whole cells, and each plane runs `NPLANES` times slower than the cell rate. The external scheduler is unchanged. It still produces one matching per cell time, given per output as a selected input number and an enable bit. The block hands each cell time's matching and cells to one plane, taking the planes in rotation.

A modulo-`NPLANES` slot counter names the plane that owns the current cell time. In that cell time the plane captures the arriving cells together with the matching, and it holds both for `XFER_SLOTS` cell times while the transfer runs. When the transfer ends, the plane's switched result passes to a shared output stage. At most one plane finishes in any cell time, so results leave in the order their slots were taken. The cells of each input-output pair therefore stay in order.

With the default `XFER_SLOTS = NPLANES`, a plane is free again exactly when its slot comes round. A longer transfer setting leaves a plane still busy when its next slot arrives. In that case the new cells are dropped and an overrun pulse is raised.

Top module: `tsx_xbar`

## Requirements
- R1: While `rst_n` is low, `out_valid` is all zero, `out_cell` is zero, `out_plane` is 0 and `out_overrun` is 0. The first rising edge with `rst_n` high is slot 0.
- R2: The cells and matching sampled at the c-th rising edge after reset release (c counted from 0) go to plane c mod `NPLANES`, and `out_plane` reports that plane number when they are delivered.
- R3: A cell sampled at edge c appears on the outputs right after edge c + `XFER_SLOTS`.
- R4: Output o is valid only when `match_en[o]` is 1, the select field `match_sel[o*SELW +: SELW]` is below `NPORTS`, and the selected input had `in_valid` high. Output o then carries that input's cell. In every other case the lane is invalid and its `out_cell` slice is zero.
- R5: All valid outputs delivered in one cell time come from the same plane. A cell reaches its output whole, from a single plane.
- R6: A plane uses the matching captured in its own slot. Matching changes in later cell times do not alter cells already in flight.
- R7: If a slot carries at least one valid cell while its plane is still busy, those cells are discarded and `out_overrun` is high for the one cell time after that edge. The plane's pending delivery is unaffected.
- R8: A slot with no valid input cell leaves its plane idle. It produces no delivery and no overrun.
- R9: Deliveries leave in slot order, so successive cells of one input-output pair arrive in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_cell | input | NPORTS*CELL_W | Arriving cell per input, input i at bits i*CELL_W |
| in_valid | input | NPORTS | Cell present per input |
| match_sel | input | NPORTS*SELW | Per-output selected input number |
| match_en | input | NPORTS | Per-output connection enable |
| out_cell | output | NPORTS*CELL_W | Switched cell per output |
| out_valid | output | NPORTS | Switched cell present per output |
| out_plane | output | PLW | Plane that delivered the current outputs |
| out_overrun | output | 1 | Pulse: a slot's cells were dropped because the plane was busy |

## Verification
A lone cell on one input-output pair shows the latency and plane rotation without interference. Full random permutations with all inputs valid check the crossbar selection and the plane tag under load. Matchings redrawn every cycle, including out-of-range selects and disabled lanes, show that each plane keeps its captured matching. Sparse traffic separates idle slots from real deliveries. A second instance with a transfer longer than the rotation is driven with the same inputs, which exercises the overrun drop next to the normal instance. A run of increasing payloads on a single pair exposes any reordering between planes.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
   // index width for a count of n items, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tsx_slot_ctr.sv
module tsx_slot_ctr #(
   parameter int NPLANES = 3,
   localparam int PLW = tsx_pkg::idx_w(NPLANES)
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [PLW-1:0] slot
);
   localparam bit POW2 = (NPLANES > 1) && (NPLANES == (1 << PLW));

   generate
      if (NPLANES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot <= '0;
            else        slot <= '0;
         end
      end else if (POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot <= '0;
            else        slot <= slot + PLW'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          slot <= '0;
            else if (slot == PLW'(NPLANES - 1))  slot <= '0;
            else                                 slot <= slot + PLW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/tsx_plane.sv
module tsx_plane #(
   parameter int NPORTS     = 5,
   parameter int CELL_W     = 16,
   parameter int XFER_SLOTS = 3,
   localparam int SELW = tsx_pkg::idx_w(NPORTS),
   localparam int CNTW = $clog2(XFER_SLOTS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_req,
   input  logic [NPORTS*CELL_W-1:0] cells_in,
   input  logic [NPORTS-1:0]        valid_in,
   input  logic [NPORTS*SELW-1:0]   sel_in,
   input  logic [NPORTS-1:0]        en_in,
   output logic                     take,
   output logic                     done,
   output logic                     overrun,
   output logic [NPORTS*CELL_W-1:0] sw_cell,
   output logic [NPORTS-1:0]        sw_valid
);
   localparam bit FULL_SEL = (NPORTS == (1 << SELW));

   logic                     busy_q;
   logic [CNTW-1:0]          cnt_q;
   logic [CELL_W-1:0]        cell_q [NPORTS];
   logic [NPORTS-1:0]        vld_q;
   logic [NPORTS*SELW-1:0]   sel_q;
   logic [NPORTS-1:0]        en_q;
   logic                     has_cells;

   assign has_cells = |valid_in;
   assign done      = busy_q && (cnt_q == CNTW'(1));
   assign take      = load_req && has_cells && (!busy_q || done);
   assign overrun   = load_req && has_cells && busy_q && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         cnt_q  <= CNTW'(XFER_SLOTS);
      end else if (done) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q - CNTW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         sel_q <= '0;
         en_q  <= '0;
      end else if (take) begin
         vld_q <= valid_in;
         sel_q <= sel_in;
         en_q  <= en_in;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NPORTS; gi++) begin : g_cap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cell_q[gi] <= '0;
            else if (take) cell_q[gi] <= cells_in[gi*CELL_W +: CELL_W];
         end
      end

      for (gi = 0; gi < NPORTS; gi++) begin : g_lane
         logic [SELW-1:0] lane_sel;
         logic            in_range;
         logic            lane_ok;
         assign lane_sel = sel_q[gi*SELW +: SELW];
         if (FULL_SEL) begin : g_full
            assign in_range = 1'b1;
         end else begin : g_part
            assign in_range = (lane_sel < SELW'(NPORTS));
         end
         assign lane_ok = busy_q && en_q[gi] && in_range && vld_q[lane_sel];
         assign sw_valid[gi] = lane_ok;
         assign sw_cell[gi*CELL_W +: CELL_W] = lane_ok ? cell_q[lane_sel] : '0;
      end
   endgenerate
endmodule

// File: rtl/tsx_merge.sv
module tsx_merge #(
   parameter int NPORTS  = 5,
   parameter int NPLANES = 3,
   parameter int CELL_W  = 16,
   localparam int PLW  = tsx_pkg::idx_w(NPLANES),
   localparam int LANE = NPORTS * CELL_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NPLANES-1:0]          done_vec,
   input  logic [NPLANES*LANE-1:0]     cells_flat,
   input  logic [NPLANES*NPORTS-1:0]   valid_flat,
   output logic [LANE-1:0]             out_cell,
   output logic [NPORTS-1:0]           out_valid,
   output logic [PLW-1:0]              out_plane
);
   logic [LANE-1:0]   mux_cell;
   logic [NPORTS-1:0] mux_valid;
   logic [PLW-1:0]    mux_plane;

   generate
      if (NPLANES == 1) begin : g_one
         assign mux_cell  = cells_flat;
         assign mux_valid = valid_flat;
         assign mux_plane = '0;
      end else begin : g_many
         always_comb begin
            mux_cell  = '0;
            mux_valid = '0;
            mux_plane = '0;
            for (int p = 0; p < NPLANES; p++) begin
               if (done_vec[p]) begin
                  mux_cell  = mux_cell  | cells_flat[p*LANE +: LANE];
                  mux_valid = mux_valid | valid_flat[p*NPORTS +: NPORTS];
                  mux_plane = mux_plane | PLW'(p);
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_cell  <= '0;
         out_valid <= '0;
         out_plane <= '0;
      end else if (|done_vec) begin
         out_cell  <= mux_cell;
         out_valid <= mux_valid;
         out_plane <= mux_plane;
      end else begin
         out_cell  <= '0;
         out_valid <= '0;
      end
   end
endmodule

// File: rtl/tsx_xbar.sv
module tsx_xbar #(
   parameter int NPORTS     = 5,
   parameter int NPLANES    = 3,
   parameter int CELL_W     = 16,
   parameter int XFER_SLOTS = NPLANES,
   localparam int SELW = tsx_pkg::idx_w(NPORTS),
   localparam int PLW  = tsx_pkg::idx_w(NPLANES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORTS*CELL_W-1:0] in_cell,
   input  logic [NPORTS-1:0]        in_valid,
   input  logic [NPORTS*SELW-1:0]   match_sel,
   input  logic [NPORTS-1:0]        match_en,
   output logic [NPORTS*CELL_W-1:0] out_cell,
   output logic [NPORTS-1:0]        out_valid,
   output logic [PLW-1:0]           out_plane,
   output logic                     out_overrun
);
   localparam int LANE = NPORTS * CELL_W;

   generate
      if (NPORTS < 2)     begin : g_bad_ports  $error("NPORTS must be at least 2");   end
      if (NPLANES < 1)    begin : g_bad_planes $error("NPLANES must be at least 1");  end
      if (CELL_W < 1)     begin : g_bad_width  $error("CELL_W must be at least 1");   end
      if (XFER_SLOTS < 1) begin : g_bad_xfer   $error("XFER_SLOTS must be at least 1"); end
   endgenerate

   logic [PLW-1:0]              slot;
   logic [NPLANES-1:0]          plane_take;
   logic [NPLANES-1:0]          plane_done;
   logic [NPLANES-1:0]          plane_ovr;
   logic [NPLANES*LANE-1:0]     plane_cell;
   logic [NPLANES*NPORTS-1:0]   plane_valid;

   tsx_slot_ctr #(.NPLANES(NPLANES)) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .slot (slot)
   );

   genvar gp;
   generate
      for (gp = 0; gp < NPLANES; gp++) begin : g_plane
         logic load_here;
         assign load_here = (slot == PLW'(gp));
         tsx_plane #(
            .NPORTS    (NPORTS),
            .CELL_W    (CELL_W),
            .XFER_SLOTS(XFER_SLOTS)
         ) u_plane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_req(load_here),
            .cells_in(in_cell),
            .valid_in(in_valid),
            .sel_in  (match_sel),
            .en_in   (match_en),
            .take    (plane_take[gp]),
            .done    (plane_done[gp]),
            .overrun (plane_ovr[gp]),
            .sw_cell (plane_cell[gp*LANE +: LANE]),
            .sw_valid(plane_valid[gp*NPORTS +: NPORTS])
         );
      end
   endgenerate

   tsx_merge #(
      .NPORTS (NPORTS),
      .NPLANES(NPLANES),
      .CELL_W (CELL_W)
   ) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_vec  (plane_done),
      .cells_flat(plane_cell),
      .valid_flat(plane_valid),
      .out_cell  (out_cell),
      .out_valid (out_valid),
      .out_plane (out_plane)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_overrun <= 1'b0;
      else        out_overrun <= |plane_ovr;
   end
endmodule

// File: rtl/tsx_xbar_chk.sv
module tsx_xbar_chk #(
   parameter int NPORTS     = 5,
   parameter int NPLANES    = 3,
   parameter int XFER_SLOTS = 3,
   localparam int PLW = tsx_pkg::idx_w(NPLANES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PLW-1:0]     slot,
   input logic [NPLANES-1:0] plane_take,
   input logic [NPLANES-1:0] plane_done,
   input logic [NPORTS-1:0]  in_valid,
   input logic [NPORTS-1:0]  out_valid,
   input logic               out_overrun
);
   localparam int DONE_LAG = XFER_SLOTS % NPLANES;

   // R2
   slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == PLW'(NPLANES - 1)) |=> (slot == '0));

   // R2
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot != PLW'(NPLANES - 1)) |=> (slot == $past(slot) + PLW'(1)));

   // R5
   one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(plane_done));

   // R5
   one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(plane_take));

   // R3
   done_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|plane_done) |-> plane_done[(int'(slot) + NPLANES - DONE_LAG) % NPLANES]);

   // R8
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_overrun |-> $past(|in_valid));

   // R4
   valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|out_valid) |-> $past(|plane_done));
endmodule

bind tsx_xbar tsx_xbar_chk #(
   .NPORTS    (NPORTS),
   .NPLANES   (NPLANES),
   .XFER_SLOTS(XFER_SLOTS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .slot       (slot),
   .plane_take (plane_take),
   .plane_done (plane_done),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .out_overrun(out_overrun)
);

// File: tb/tb_tsx_xbar.sv
module tb_tsx_xbar;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 5;
   localparam int K    = 3;
   localparam int W    = 16;
   localparam int SELW = 3;
   localparam int PLW  = 2;
   localparam int XF0  = 3;
   localparam int XF1  = 5;

   typedef struct packed {
      logic [N*W-1:0] c;
      logic [N-1:0]   v;
      logic [PLW-1:0] p;
   } del_t;

   logic clk = 0;
   logic rst_n = 0;
   logic [N*W-1:0]  in_cell = '0;
   logic [N-1:0]    in_valid = '0;
   logic [N*SELW-1:0] match_sel = '0;
   logic [N-1:0]    match_en = '0;

   logic [N*W-1:0] oc [2];
   logic [N-1:0]   ov [2];
   logic [PLW-1:0] op [2];
   logic           oo [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   tsx_xbar #(.NPORTS(N), .NPLANES(K), .CELL_W(W), .XFER_SLOTS(XF0)) dut (
      .clk(clk), .rst_n(rst_n), .in_cell(in_cell), .in_valid(in_valid),
      .match_sel(match_sel), .match_en(match_en),
      .out_cell(oc[0]), .out_valid(ov[0]), .out_plane(op[0]), .out_overrun(oo[0]));

   tsx_xbar #(.NPORTS(N), .NPLANES(K), .CELL_W(W), .XFER_SLOTS(XF1)) dut_slow (
      .clk(clk), .rst_n(rst_n), .in_cell(in_cell), .in_valid(in_valid),
      .match_sel(match_sel), .match_en(match_en),
      .out_cell(oc[1]), .out_valid(ov[1]), .out_plane(op[1]), .out_overrun(oo[1]));

   int n_chk = 0;
   int n_fail = 0;
   string phase = "R1";

   // behavioural reference model
   longint cyc = 0;
   bit     running = 0;
   longint free_at [2][K];
   del_t   sched [longint];
   bit     ovr_at [longint];
   del_t   exp_d [2];
   bit     exp_o [2];

   initial begin
      for (int m = 0; m < 2; m++) begin
         for (int p = 0; p < K; p++) free_at[m][p] = 0;
         exp_d[m] = '0;
         exp_o[m] = 0;
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         for (int m = 0; m < 2; m++) begin
            int xf;
            int p;
            xf = (m == 0) ? XF0 : XF1;
            p  = int'(cyc % K);
            if (|in_valid) begin
               if (free_at[m][p] > cyc) begin
                  ovr_at[cyc*2 + m] = 1;
               end else begin
                  del_t d;
                  free_at[m][p] = cyc + xf;
                  d = '0;
                  d.p = PLW'(p);
                  for (int o = 0; o < N; o++) begin
                     int s;
                     s = int'(match_sel[o*SELW +: SELW]);
                     if (match_en[o] && s < N && in_valid[s]) begin
                        d.v[o] = 1'b1;
                        d.c[o*W +: W] = in_cell[s*W +: W];
                     end
                  end
                  sched[(cyc + xf)*2 + m] = d;
               end
            end
            exp_d[m] = sched.exists(cyc*2 + m) ? sched[cyc*2 + m] : '0;
            exp_o[m] = ovr_at.exists(cyc*2 + m);
         end
         running = 1;
         cyc++;
      end
   end

   task automatic check(string req, string what, int m, logic [N*W-1:0] got, logic [N*W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s inst%0d cyc%0d: got %h expected %h", req, what, m, cyc, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int m = 0; m < 2; m++) begin
            // R1 reset state
            check("R1", "valid", m, N*W'(ov[m]), '0);
            check("R1", "cell", m, oc[m], '0);
            check("R1", "plane", m, N*W'(op[m]), '0);
            check("R1", "overrun", m, N*W'(oo[m]), '0);
         end
      end else if (running) begin
         for (int m = 0; m < 2; m++) begin
            check(phase, "valid", m, N*W'(ov[m]), N*W'(exp_d[m].v));
            check(phase, "cell", m, oc[m], exp_d[m].c);
            if (|exp_d[m].v)
               check("R2,R5", "plane", m, N*W'(op[m]), N*W'(exp_d[m].p));
            check("R7", "overrun", m, N*W'(oo[m]), N*W'(exp_o[m]));
         end
      end
   end

   task automatic idle_inputs();
      in_valid  = '0;
      match_en  = '0;
      match_sel = '0;
      in_cell   = '0;
   endtask

   task automatic rand_cycle(int vprob, bit oor);
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         in_cell[i*W +: W] = W'($urandom);
         in_valid[i] = (($urandom % 100) < vprob);
         match_en[i] = (($urandom % 8) != 0);
         match_sel[i*SELW +: SELW] = oor ? SELW'($urandom % 8) : SELW'($urandom % N);
      end
   endtask

   task automatic stimulus();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2 R3: a single pair, lone cells spaced out, then back to back
      phase = "R3";
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         idle_inputs();
         if (i % 4 == 0 || i >= 8) begin
            in_valid[1] = 1'b1;
            in_cell[1*W +: W] = W'(16'hA000 + i);
            match_en[3] = 1'b1;
            match_sel[3*SELW +: SELW] = SELW'(1);
         end
      end
      // R4: full random permutations, all inputs valid
      phase = "R4";
      for (int i = 0; i < 120; i++) begin
         int perm [N];
         @(negedge clk);
         for (int a = 0; a < N; a++) perm[a] = a;
         for (int a = N-1; a > 0; a--) begin
            int b, t;
            b = int'($urandom % (a+1));
            t = perm[a]; perm[a] = perm[b]; perm[b] = t;
         end
         for (int o = 0; o < N; o++) begin
            in_cell[o*W +: W] = W'($urandom);
            in_valid[o] = 1'b1;
            match_en[o] = 1'b1;
            match_sel[o*SELW +: SELW] = SELW'(perm[o]);
         end
      end
      // R6: matching redrawn every cycle, out-of-range selects and disabled lanes
      phase = "R6";
      for (int i = 0; i < 120; i++) rand_cycle(70, 1);
      // R8: sparse traffic, many idle slots
      phase = "R8";
      for (int i = 0; i < 120; i++) rand_cycle(12, 1);
      // R9: one pair every cycle with rising payloads
      phase = "R9";
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         idle_inputs();
         in_valid[2] = 1'b1;
         in_cell[2*W +: W] = W'(16'h5000 + i);
         match_en[4] = 1'b1;
         match_sel[4*SELW +: SELW] = SELW'(2);
      end
      @(negedge clk);
      idle_inputs();
      repeat (12) @(negedge clk);
   endtask

   initial begin
      fork
         stimulus();
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule